// File: doc/BRIEF.md
# Power-Fail-Protected Memory Access Gate

This block stands between a host's asynchronous memory bus and two targets: a window of sixteen on-chip timekeeping and control registers at the very top of a 19-bit address space, and an external SRAM that fills the rest of the space. It decodes each address to pick one target. It forms the SRAM chip-select and output-enable strobes, the internal register select and the data-drive enable. It also turns host write cycles into a one-cycle register write strobe that carries a 4-bit register index. The host strobes and the power-fail flag are asynchronous. Each one passes through a two-flop synchroniser clocked by the system clock.

A power-fail indication locks the block. While it is locked, neither target can be selected, nothing drives the data bus, no register write is accepted and the system reset output is held low. When the flag clears, the lock stays on for a programmable number of clocks and then releases. The same hold-off runs after the block's own reset.

The lock is a three-state machine. LK_RUN goes to LK_FAIL when the power-fail flag is seen. LK_FAIL goes to LK_HOLD, with the counter cleared, once the flag is gone. LK_HOLD goes back to LK_FAIL if the flag returns, and goes to LK_RUN after HOLD_CYC cycles. Reset enters LK_HOLD. The write tracker is a second three-state machine. WR_IDLE goes to WR_OPEN when a write starts while the block is unlocked, or to WR_DROP when a write starts while it is locked. WR_OPEN goes to WR_DROP if the lock engages. WR_OPEN goes back to WR_IDLE when the write ends, and emits the strobe as it does. WR_DROP goes back to WR_IDLE when the write ends and emits nothing.

Top module: `pwrfail_mem_gate`

## Requirements
- R1: An address from 0x7FFF0 to 0x7FFFF inclusive selects the register window. Every other address selects the SRAM. `ext_ce_n` is low exactly when the synchronised host chip enable is low, the address selects the SRAM and the block is unlocked.
- R2: `reg_ce_n` is low exactly when the synchronised chip enable is low, the address is in the register window and the block is unlocked. `reg_ce_n` and `ext_ce_n` are never low together.
- R3: `ext_oe_n` equals the synchronised host output enable for SRAM addresses. It is high for register-window addresses.
- R4: `reg_dout_en` is high only while chip enable and output enable are low, write enable is high, the address is in the register window and the block is unlocked. A falling write enable drops it. If chip enable and write enable fall together, it never rises during that cycle.
- R5: A write is active only while chip enable and write enable are both low. A write that starts while the block is unlocked and whose address is in the register window produces exactly one `reg_wr_stb` pulse, one clock long. The pulse comes in the cycle after the first of the two strobes rises. During the pulse, `reg_idx` holds address bits [3:0] as captured when the write started. Writes to SRAM addresses produce no pulse.
- R6: While the block is locked, `ext_ce_n` and `reg_ce_n` are high, `reg_dout_en` is low and `sys_rst_n` is low.
- R7: After the synchronised power-fail flag clears, the lock and the low `sys_rst_n` persist for HOLD_CYC further clocks. The same hold-off follows the block reset.
- R8: If power-fail reasserts during the hold-off, the block locks again and a full hold-off restarts when the flag next clears.
- R9: A write that is open when the lock engages, or that starts while the block is locked, never produces a write pulse, even after it ends.
- R10: Host strobes and the power-fail flag each pass through two synchronising flops. A strobe change reaches the outputs after the second rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| host_addr | input | 19 | Host address, stable for the whole access |
| host_ce_n | input | 1 | Host chip enable, active low, asynchronous |
| host_we_n | input | 1 | Host write enable, active low, asynchronous |
| host_oe_n | input | 1 | Host output enable, active low, asynchronous |
| pwr_fail | input | 1 | Power-fail indication, active high, asynchronous |
| ext_ce_n | output | 1 | SRAM chip select, active low |
| ext_oe_n | output | 1 | SRAM output enable, active low |
| reg_ce_n | output | 1 | Register window select, active low |
| reg_dout_en | output | 1 | Enable for driving register read data onto the bus |
| reg_wr_stb | output | 1 | One-cycle register write pulse |
| reg_idx | output | 4 | Register index for the write pulse |
| sys_rst_n | output | 1 | System reset output, active low |

## Verification
The bench exercises both edges of the register window: 0x7FFEF, 0x7FFF0 and 0x7FFFF. A decoder that is off by one sends one of these accesses to the wrong chip select. It lowers write enable during a register read, and also lowers chip enable and write enable together. A data enable that ignored write enable would then drive the bus during a write. It opens writes in both strobe orders and raises power-fail in the middle of an open register write. A tracker that pulsed on the lower strobe's fall, or that forgot the lock, would emit a stray or late `reg_wr_stb`. It also measures the reset release after a plain recovery and after a power-fail pulse in mid hold-off. A counter that was not reloaded would release early.

// File: rtl/pwrfail_gate_pkg.sv
package pwrfail_gate_pkg;

    typedef enum logic [1:0] {
        LK_RUN  = 2'd0,
        LK_FAIL = 2'd1,
        LK_HOLD = 2'd2
    } lock_state_e;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_OPEN = 2'd1,
        WR_DROP = 2'd2
    } wr_state_e;

endpackage

// File: rtl/pwrfail_sync.sv
module pwrfail_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

    initial begin
        // R10
        stages_min_chk: assert (STAGES >= 2);
    end
endmodule

// File: rtl/pwrfail_lock.sv
module pwrfail_lock
    import pwrfail_gate_pkg::*;
#(
    parameter int HOLD_CYC = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_s,
    output logic locked
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    lock_state_e state, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            LK_RUN:  if (pf_s) nxt = LK_FAIL;
            LK_FAIL: if (!pf_s) nxt = LK_HOLD;
            LK_HOLD: begin
                if (pf_s)             nxt = LK_FAIL;
                else if (cnt == LAST) nxt = LK_RUN;
            end
            default: nxt = LK_FAIL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_HOLD;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == LK_HOLD && nxt == LK_HOLD) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    always_comb locked = (state != LK_RUN);

    // R6
    pf_forces_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_s |=> (state == LK_FAIL));
    // R7
    hold_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_HOLD && !pf_s && cnt != LAST) |=> (state == LK_HOLD));
    // R8
    hold_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_FAIL && !pf_s) |=> (state == LK_HOLD && cnt == '0));
endmodule

// File: rtl/pwrfail_wr.sv
module pwrfail_wr
    import pwrfail_gate_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_s,
    input  logic             we_s,
    input  logic             unlocked,
    input  logic             in_reg,
    input  logic [IDX_W-1:0] idx_in,
    output logic             wr_stb,
    output logic [IDX_W-1:0] wr_idx
);
    wr_state_e state, nxt;
    logic      act;
    logic      cap_reg;

    always_comb act = !ce_s && !we_s;

    always_comb begin
        nxt = state;
        unique case (state)
            WR_IDLE: if (act) nxt = unlocked ? WR_OPEN : WR_DROP;
            WR_OPEN: begin
                if (!unlocked) nxt = WR_DROP;
                else if (!act) nxt = WR_IDLE;
            end
            WR_DROP: if (!act) nxt = WR_IDLE;
            default: nxt = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_idx  <= '0;
            cap_reg <= 1'b0;
        end else begin
            wr_stb <= (state == WR_OPEN) && unlocked && !act && cap_reg;
            if (state == WR_IDLE && act) begin
                cap_reg <= in_reg;
                wr_idx  <= idx_in;
            end
        end
    end

    // R5
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    // R5
    stb_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(ce_s || we_s));
    // R9
    stb_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(unlocked));
endmodule

// File: rtl/pwrfail_mem_gate.sv
module pwrfail_mem_gate
    import pwrfail_gate_pkg::*;
#(
    parameter int AW          = 19,
    parameter int IDX_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 20_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    host_addr,
    input  logic             host_ce_n,
    input  logic             host_we_n,
    input  logic             host_oe_n,
    input  logic             pwr_fail,
    output logic             ext_ce_n,
    output logic             ext_oe_n,
    output logic             reg_ce_n,
    output logic             reg_dout_en,
    output logic             reg_wr_stb,
    output logic [IDX_W-1:0] reg_idx,
    output logic             sys_rst_n
);
    localparam int NSIG = 4;

    logic [NSIG-1:0] raw, syn;
    logic ce_s, we_s, oe_s, pf_s;
    logic locked, unlocked;
    logic in_reg, in_sram;

    assign raw = {host_ce_n, host_we_n, host_oe_n, pwr_fail};

    pwrfail_sync #(
        .W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign {ce_s, we_s, oe_s, pf_s} = syn;

    // Register window: every address bit above the index field set.
    always_comb begin
        in_reg  = &host_addr[AW-1:IDX_W];
        in_sram = !in_reg;
    end

    pwrfail_lock #(.HOLD_CYC(HOLD_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .pf_s(pf_s), .locked(locked)
    );

    assign unlocked = !locked;

    pwrfail_wr #(.IDX_W(IDX_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .we_s(we_s),
        .unlocked(unlocked), .in_reg(in_reg),
        .idx_in(host_addr[IDX_W-1:0]),
        .wr_stb(reg_wr_stb), .wr_idx(reg_idx)
    );

    always_comb begin
        ext_ce_n    = !(!ce_s && in_sram && unlocked);
        reg_ce_n    = !(!ce_s && in_reg && unlocked);
        ext_oe_n    = oe_s || in_reg;
        reg_dout_en = !ce_s && !oe_s && we_s && in_reg && unlocked;
        sys_rst_n   = unlocked;
    end

    // R6
    lock_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (ext_ce_n && reg_ce_n && !reg_dout_en && !sys_rst_n));
    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_ce_n && !reg_ce_n));
    // R4
    no_drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_s |-> !reg_dout_en);
endmodule

// File: tb/pwrfail_mem_gate_tb.sv
`timescale 1ns/1ps
module pwrfail_mem_gate_tb;
    localparam int HOLD = 40;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [18:0] host_addr;
    logic        host_ce_n, host_we_n, host_oe_n, pwr_fail;
    logic        ext_ce_n, ext_oe_n, reg_ce_n, reg_dout_en, reg_wr_stb, sys_rst_n;
    logic [3:0]  reg_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwrfail_mem_gate #(.HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
        .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
        .pwr_fail(pwr_fail), .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n),
        .reg_ce_n(reg_ce_n), .reg_dout_en(reg_dout_en),
        .reg_wr_stb(reg_wr_stb), .reg_idx(reg_idx), .sys_rst_n(sys_rst_n)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit is_reg(input logic [18:0] a);
        return a >= 19'h7FFF0;
    endfunction

    // Reference model: two-deep sampling queues, integer lock and write states.
    bit [1:0] q_ce, q_we, q_oe, q_pf;
    int mlk, mcnt, mws;
    bit misint, mstb;
    int midx;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_ce = 2'b11; q_we = 2'b11; q_oe = 2'b11; q_pf = 2'b00;
            mlk = 2; mcnt = 0; mws = 0; misint = 0; mstb = 0; midx = 0;
        end else begin
            bit act, run, nstb;
            act = !q_ce[1] && !q_we[1];
            run = (mlk == 0);
            nstb = (mws == 1) && run && !act && misint;
            case (mws)
                0: if (act) begin
                       misint = is_reg(host_addr);
                       midx = int'(host_addr[3:0]);
                       mws = run ? 1 : 2;
                   end
                1: if (!run) mws = 2; else if (!act) mws = 0;
                default: if (!act) mws = 0;
            endcase
            mstb = nstb;
            if (mlk == 0) begin
                if (q_pf[1]) mlk = 1;
            end else if (mlk == 1) begin
                if (!q_pf[1]) begin mlk = 2; mcnt = 0; end
            end else begin
                if (q_pf[1]) begin mlk = 1; mcnt = 0; end
                else if (mcnt == HOLD - 1) begin mlk = 0; mcnt = 0; end
                else mcnt++;
            end
            q_ce = {q_ce[0], host_ce_n};
            q_we = {q_we[0], host_we_n};
            q_oe = {q_oe[0], host_oe_n};
            q_pf = {q_pf[0], pwr_fail};
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            bit run, ir, e_ext, e_reg, e_oe, e_dout;
            run = (mlk == 0);
            ir = is_reg(host_addr);
            e_ext  = !(!q_ce[1] && !ir && run);
            e_reg  = !(!q_ce[1] && ir && run);
            e_oe   = q_oe[1] || ir;
            e_dout = !q_ce[1] && !q_oe[1] && q_we[1] && ir && run;
            chk(ext_ce_n == e_ext, "R1", "model ext_ce_n", ext_ce_n, e_ext);
            chk(reg_ce_n == e_reg, "R2", "model reg_ce_n", reg_ce_n, e_reg);
            chk(ext_oe_n == e_oe, "R3", "model ext_oe_n", ext_oe_n, e_oe);
            chk(reg_dout_en == e_dout, "R4", "model reg_dout_en", reg_dout_en, e_dout);
            chk(reg_wr_stb == mstb, "R5", "model reg_wr_stb", reg_wr_stb, mstb);
            chk(int'(reg_idx) == midx, "R5", "model reg_idx", reg_idx, midx);
            chk(sys_rst_n == run, "R7", "model sys_rst_n", sys_rst_n, run);
        end
    end

    int stb_cnt = 0;
    int last_idx = -1;
    bit dout_seen = 0;
    always @(negedge clk) begin
        if (reg_wr_stb) begin stb_cnt++; last_idx = int'(reg_idx); end
        if (reg_dout_en) dout_seen = 1;
    end

    task automatic at_edge();
        @(posedge clk); #1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic measure_release(output int k);
        k = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (sys_rst_n) break;
            k++;
        end
    endtask

    task automatic bus_idle();
        at_edge();
        host_ce_n = 1; host_we_n = 1; host_oe_n = 1;
        wait_cyc(4);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        rst_n = 0; host_addr = '0; host_ce_n = 1; host_we_n = 1; host_oe_n = 1; pwr_fail = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(sys_rst_n == 0, "R7", "reset held after block reset", sys_rst_n, 0);
        chk(ext_ce_n == 1 && reg_wr_stb == 0, "R6", "idle outputs at reset", ext_ce_n, 1);
        wait_cyc(HOLD + 10);
        chk(sys_rst_n == 1, "R7", "reset released after hold-off", sys_rst_n, 1);

        // R10 latency and R1/R3 SRAM read
        at_edge();
        host_addr = 19'h12345; host_ce_n = 0; host_oe_n = 0;
        @(negedge clk);
        chk(ext_ce_n == 1, "R10", "ext_ce_n before first sync edge", ext_ce_n, 1);
        @(negedge clk);
        chk(ext_ce_n == 1, "R10", "ext_ce_n after one edge", ext_ce_n, 1);
        @(negedge clk);
        chk(ext_ce_n == 0, "R10", "ext_ce_n after two edges", ext_ce_n, 0);
        chk(ext_oe_n == 0, "R3", "ext_oe_n follows oe for SRAM", ext_oe_n, 0);
        chk(reg_ce_n == 1, "R2", "reg_ce_n idle for SRAM", reg_ce_n, 1);
        bus_idle();

        // Register read, then write enable falls during it
        stb_cnt = 0;
        at_edge();
        host_addr = 19'h7FFF5; host_ce_n = 0; host_oe_n = 0;
        wait_cyc(3);
        chk(reg_ce_n == 0, "R2", "reg_ce_n for register read", reg_ce_n, 0);
        chk(ext_ce_n == 1, "R1", "ext_ce_n for register read", ext_ce_n, 1);
        chk(ext_oe_n == 1, "R3", "ext_oe_n held for register range", ext_oe_n, 1);
        chk(reg_dout_en == 1, "R4", "data driven on register read", reg_dout_en, 1);
        at_edge(); host_we_n = 0;
        wait_cyc(3);
        chk(reg_dout_en == 0, "R4", "falling we drops data drive", reg_dout_en, 0);
        bus_idle();
        chk(stb_cnt == 1 && last_idx == 5, "R5", "strobe index after read-then-write", last_idx, 5);

        // Window boundaries
        at_edge(); host_addr = 19'h7FFEF; host_ce_n = 0;
        wait_cyc(3);
        chk(ext_ce_n == 0 && reg_ce_n == 1, "R1", "0x7FFEF selects SRAM", ext_ce_n, 0);
        bus_idle();
        at_edge(); host_addr = 19'h7FFF0; host_ce_n = 0;
        wait_cyc(3);
        chk(reg_ce_n == 0 && ext_ce_n == 1, "R2", "0x7FFF0 selects registers", reg_ce_n, 0);
        bus_idle();
        at_edge(); host_addr = 19'h7FFFF; host_ce_n = 0;
        wait_cyc(3);
        chk(reg_ce_n == 0 && ext_ce_n == 1, "R2", "0x7FFFF selects registers", reg_ce_n, 0);
        bus_idle();

        // Simultaneous ce and we fall with oe already low
        stb_cnt = 0;
        at_edge(); host_addr = 19'h7FFF3; host_oe_n = 0;
        wait_cyc(3);
        dout_seen = 0;
        at_edge(); host_ce_n = 0; host_we_n = 0;
        wait_cyc(6);
        chk(dout_seen == 0, "R4", "no drive when ce and we fall together", dout_seen, 0);
        bus_idle();
        wait_cyc(2);
        chk(stb_cnt == 1 && last_idx == 3, "R5", "strobe after simultaneous write", last_idx, 3);

        // we first, then ce; ce rises first
        stb_cnt = 0;
        at_edge(); host_addr = 19'h7FFF9; host_we_n = 0;
        wait_cyc(2);
        at_edge(); host_ce_n = 0;
        wait_cyc(4);
        chk(stb_cnt == 0, "R5", "no strobe while write open", stb_cnt, 0);
        at_edge(); host_ce_n = 1;
        wait_cyc(5);
        chk(stb_cnt == 1 && last_idx == 9, "R5", "strobe when ce rises first", last_idx, 9);
        at_edge(); host_we_n = 1;
        wait_cyc(4);
        chk(stb_cnt == 1, "R5", "single strobe per write", stb_cnt, 1);

        // SRAM write: no strobe
        stb_cnt = 0;
        at_edge(); host_addr = 19'h00ABC; host_ce_n = 0; host_we_n = 0;
        wait_cyc(4);
        bus_idle();
        wait_cyc(2);
        chk(stb_cnt == 0, "R5", "no strobe for SRAM write", stb_cnt, 0);

        // Power-fail lockout and plain recovery
        at_edge(); pwr_fail = 1; host_addr = 19'h01000; host_ce_n = 0; host_oe_n = 0;
        wait_cyc(5);
        chk(ext_ce_n == 1, "R6", "ext_ce_n forced high", ext_ce_n, 1);
        chk(sys_rst_n == 0, "R6", "reset driven during power fail", sys_rst_n, 0);
        at_edge(); host_addr = 19'h7FFF1;
        wait_cyc(3);
        chk(reg_ce_n == 1 && reg_dout_en == 0, "R6", "registers deselected", reg_ce_n, 1);
        bus_idle();
        at_edge(); pwr_fail = 0;
        measure_release(k);
        chk(k == HOLD + 3, "R7", "hold-off length after recovery", k, HOLD + 3);

        // Lock engages during an open register write
        stb_cnt = 0;
        at_edge(); host_addr = 19'h7FFF2; host_ce_n = 0; host_we_n = 0;
        wait_cyc(4);
        at_edge(); pwr_fail = 1;
        wait_cyc(5);
        bus_idle();
        at_edge(); pwr_fail = 0;
        measure_release(k);
        wait_cyc(4);
        chk(stb_cnt == 0, "R9", "aborted write gives no strobe", stb_cnt, 0);

        // Reassert during hold-off restarts it
        at_edge(); pwr_fail = 1;
        wait_cyc(5);
        at_edge(); pwr_fail = 0;
        wait_cyc(20);
        at_edge(); pwr_fail = 1;
        wait_cyc(4);
        chk(sys_rst_n == 0, "R8", "reset held after mid hold-off fail", sys_rst_n, 0);
        at_edge(); pwr_fail = 0;
        measure_release(k);
        chk(k == HOLD + 3, "R8", "full hold-off after reload", k, HOLD + 3);

        // Writes accepted again
        stb_cnt = 0;
        at_edge(); host_addr = 19'h7FFFC; host_ce_n = 0; host_we_n = 0;
        wait_cyc(3);
        bus_idle();
        wait_cyc(2);
        chk(stb_cnt == 1 && last_idx == 12, "R5", "write after recovery", last_idx, 12);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule